// File: doc/BRIEF.md
# Sound Coprocessor Memory Access Unit

This unit sits between the core of an 8-bit sound processor and its memory. The core has a 16-bit address space. The unit accepts one request at a time on a valid/ready handshake. A request is an idle stretch, an absolute read or write, a direct-page read or write, a stack push or pop, or an opcode fetch. The unit forms the bus address and steers the access to one of three places:

- a 16-entry I/O register window,
- a small boot ROM overlay that can be switched off,
- the work RAM.

The unit holds the program counter and the stack pointer. A fetch advances the program counter. A push or pop moves the stack pointer. The core can load either register directly.

Every access cycle and every idle cycle raises a single-cycle `tick`. Timers and the DSP cycle counter outside this block advance on that pulse. The unit also keeps a running count of ticks.

The work RAM is synchronous. Its depth is set by `RAM_AW`, and the RAM index is the low `RAM_AW` bits of the bus address. `RAM_AW = 16` gives the full 64 KiB. The default of 10 gives a 1 KiB RAM that aliases across the address space.

Top module: `sound_bus_unit`

## Requirements
- R1: Reset state:
  - `reqReady` is 1.
  - `rspValid` and `tick` are 0.
  - `sp` is 0xFF and `pc` is 0xFFC0.
  - `cycleCount` is 0.
- R2: `reqOp` codes are: 0 idle, 1 read, 2 write, 3 direct-page read, 4 direct-page write, 5 push, 6 pop, 7 fetch.
  - A request is accepted on a clock edge where `reqValid` and `reqReady` are both high.
  - For a read-type op (1, 3, 6, 7), the cycle after acceptance has `rspValid` = 1, `reqReady` = 0 and the read byte on `rspData`.
  - After that cycle, `reqReady` returns to 1.
- R3: A read at bus address 0x00F0–0x00FF returns `ioRdData` instead of RAM.
  - In the acceptance cycle, `ioRdEn` pulses and `ioAddr` equals address bits [3:0].
- R4: A write at 0x00F0–0x00FF pulses `ioWrEn` with `ioAddr` = address bits [3:0] and `ioWData` equal to the write data.
  - The same byte is also stored in RAM. Every write updates RAM.
- R5: While `romEnable` = 1, a read at 0xFFC0 or above returns the boot ROM byte `({i,2'b01}) ^ 8'hC3`, where i is address bits [5:0].
  - While `romEnable` = 0, such a read returns RAM.
  - Writes in this range always go to RAM.
  - Decode priority is the I/O window, then the ROM, then RAM.
- R6: The RAM location used is the bus address taken modulo 2^`RAM_AW`. With the default of 10, this is the address AND 0x3FF.
- R7: A direct-page op uses the bus address {7'b0, `dpFlag`, `reqAddr[7:0]`}. `reqAddr[15:8]` is ignored.
- R8: Push writes to 0x0100+SP and then decrements SP. Pop first increments SP and then reads 0x0100+SP.
  - SP wraps within 8 bits.
  - `spLoad` loads `spLoadVal`.
- R9: Fetch reads at the address in `pc` and then increments `pc`, with 16-bit wrap.
  - No other op changes `pc`.
  - `pcLoad` loads `pcLoadVal`.
- R10: `tick` is high for one cycle on each accepted non-idle request.
  - An idle request with count n raises `tick` for max(n,1) consecutive cycles and holds `reqReady` low until they finish.
  - `cycleCount` equals the number of ticks since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Request operation code |
| reqAddr | input | 16 | Absolute address, or operand byte for direct-page ops |
| reqWData | input | 8 | Write data for write and push |
| reqCount | input | 8 | Idle length in cycles (0 counts as 1) |
| reqReady | output | 1 | Unit can accept a request |
| rspValid | output | 1 | Read data valid |
| rspData | output | 8 | Read data |
| dpFlag | input | 1 | Direct-page select (address bit 8) |
| romEnable | input | 1 | Boot ROM overlay enable |
| pcLoad | input | 1 | Load program counter |
| pcLoadVal | input | 16 | Program counter load value |
| spLoad | input | 1 | Load stack pointer |
| spLoadVal | input | 8 | Stack pointer load value |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| ioRdEn | output | 1 | I/O register read strobe |
| ioWrEn | output | 1 | I/O register write strobe |
| ioAddr | output | 4 | I/O register index |
| ioWData | output | 8 | I/O write data |
| ioRdData | input | 8 | I/O read data, sampled in the acceptance cycle |
| tick | output | 1 | One pulse per bus or idle cycle |
| cycleCount | output | CNT_W (16) | Ticks since reset |

## Verification
The hardest case to reach from the ports is a location that is both an overlay and RAM. Such a location holds RAM data that the normal read path hides, either behind the I/O window or behind the enabled ROM.

The bench gets there in two steps. It first writes through aliased high addresses and through the I/O window, and writes to the ROM range while the ROM is enabled. It then reads the same RAM index back, either through an alias above the window or with the ROM switched off. Stack wrap across page 0x01 and program-counter wrap into the ROM are set up by loading SP and PC directly before the push, pop and fetch sequences.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_DPRD  = 3'd3,
    OP_DPWR  = 3'd4,
    OP_PUSH  = 3'd5,
    OP_POP   = 3'd6,
    OP_FETCH = 3'd7
  } sbuOp_t;

  typedef enum logic [1:0] {
    SRC_RAM = 2'd0,
    SRC_IO  = 2'd1,
    SRC_ROM = 2'd2
  } sbuSrc_t;

  // Control-to-datapath strobes, all valid in the acceptance cycle (tick also during idle stretch)
  typedef struct packed {
    logic ramWe;
    logic rdCapture;
    logic spInc;
    logic spDec;
    logic pcInc;
    logic tick;
  } sbuStrobe_t;

  localparam logic [11:0] IO_PAGE_HI  = 12'h00F;
  localparam logic [9:0]  ROM_PAGE_HI = 10'h3FF;
  localparam logic [7:0]  STACK_PAGE  = 8'h01;

  function automatic logic [7:0] romByte(input logic [5:0] idx);
    return {idx, 2'b01} ^ 8'hC3;
  endfunction

endpackage

// File: rtl/sbu_ram.sv
module sbu_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sbu_ctrl.sv
module sbu_ctrl
  import sbu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  sbuOp_t     reqOp,
  input  logic [7:0] reqCount,
  output logic       reqReady,
  output logic       rspValid,
  output sbuStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_WAIT} state_t;

  state_t     state;
  logic [7:0] remain;
  logic       accept, isRead, isWrite, isIdle;

  assign accept  = reqValid && (state == ST_IDLE);
  assign isRead  = (reqOp == OP_READ) || (reqOp == OP_DPRD) ||
                   (reqOp == OP_POP)  || (reqOp == OP_FETCH);
  assign isWrite = (reqOp == OP_WRITE) || (reqOp == OP_DPWR) || (reqOp == OP_PUSH);
  assign isIdle  = (reqOp == OP_IDLE);

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

  always_comb begin
    strb           = '0;
    strb.ramWe     = accept && isWrite;
    strb.rdCapture = accept && isRead;
    strb.spDec     = accept && (reqOp == OP_PUSH);
    strb.spInc     = accept && (reqOp == OP_POP);
    strb.pcInc     = accept && (reqOp == OP_FETCH);
    strb.tick      = accept || (state == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          if (isRead) state <= ST_RESP;
          else if (isIdle && reqCount > 8'd1) begin
            state  <= ST_WAIT;
            remain <= reqCount - 8'd1;
          end
        end
        ST_RESP: state <= ST_IDLE;
        ST_WAIT: begin
          remain <= remain - 8'd1;
          if (remain == 8'd1) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isRead) |=> (rspValid && !reqReady));

  // R2
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R10
  idle_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isIdle && reqCount > 8'd1) |=> (!reqReady && strb.tick));
endmodule

// File: rtl/sbu_dpath.sv
module sbu_dpath
  import sbu_pkg::*;
#(
  parameter int          RAM_AW   = 10,
  parameter int          CNT_W    = 16,
  parameter logic [15:0] RESET_PC = 16'hFFC0,
  parameter logic [7:0]  RESET_SP = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbuStrobe_t        strb,
  input  sbuOp_t            reqOp,
  input  logic [15:0]       reqAddr,
  input  logic              dpFlag,
  input  logic              romEnable,
  input  logic              pcLoad,
  input  logic [15:0]       pcLoadVal,
  input  logic              spLoad,
  input  logic [7:0]        spLoadVal,
  input  logic [7:0]        ramRData,
  input  logic [7:0]        ioRdData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        rspData,
  output logic [15:0]       pc,
  output logic [7:0]        sp,
  output logic              ioRdEn,
  output logic              ioWrEn,
  output logic [3:0]        ioAddr,
  output logic [CNT_W-1:0]  cycleCount
);
  logic [15:0] busAddr;
  logic        isIo, isRom;
  sbuSrc_t     srcSel;
  logic [5:0]  romIdx;
  logic [7:0]  ioHold;

  always_comb begin
    unique case (reqOp)
      OP_DPRD, OP_DPWR: busAddr = {7'b0, dpFlag, reqAddr[7:0]};
      OP_PUSH:          busAddr = {STACK_PAGE, sp};
      OP_POP:           busAddr = {STACK_PAGE, sp + 8'd1};
      OP_FETCH:         busAddr = pc;
      default:          busAddr = reqAddr;
    endcase
  end

  assign isIo    = (busAddr[15:4] == IO_PAGE_HI);
  assign isRom   = romEnable && (busAddr[15:6] == ROM_PAGE_HI);
  assign ramAddr = busAddr[RAM_AW-1:0];
  assign ioAddr  = busAddr[3:0];
  assign ioRdEn  = strb.rdCapture && isIo;
  assign ioWrEn  = strb.ramWe && isIo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel     <= SRC_RAM;
      romIdx     <= '0;
      ioHold     <= '0;
      pc         <= RESET_PC;
      sp         <= RESET_SP;
      cycleCount <= '0;
    end else begin
      if (strb.rdCapture) begin
        srcSel <= isIo ? SRC_IO : (isRom ? SRC_ROM : SRC_RAM);
        romIdx <= busAddr[5:0];
        if (isIo) ioHold <= ioRdData;
      end
      if (pcLoad)          pc <= pcLoadVal;
      else if (strb.pcInc) pc <= pc + 16'd1;
      if (spLoad)          sp <= spLoadVal;
      else if (strb.spDec) sp <= sp - 8'd1;
      else if (strb.spInc) sp <= sp + 8'd1;
      if (strb.tick) cycleCount <= cycleCount + 1'b1;
    end
  end

  always_comb begin
    unique case (srcSel)
      SRC_IO:  rspData = ioHold;
      SRC_ROM: rspData = romByte(romIdx);
      default: rspData = ramRData;
    endcase
  end

  // R5
  rom_overlay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCapture && romEnable && busAddr >= 16'hFFC0) |=> (rspData == romByte($past(busAddr[5:0]))));

  // R8
  push_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.spDec && !spLoad) |=> (sp == $past(sp) - 8'd1));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pcInc && !pcLoad) |=> $stable(pc));

  // R10
  tick_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (cycleCount == $past(cycleCount) + 1'b1));
endmodule

// File: rtl/sound_bus_unit.sv
module sound_bus_unit
  import sbu_pkg::*;
#(
  parameter int          RAM_AW   = 10,
  parameter int          CNT_W    = 16,
  parameter logic [15:0] RESET_PC = 16'hFFC0,
  parameter logic [7:0]  RESET_SP = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [15:0]      reqAddr,
  input  logic [7:0]       reqWData,
  input  logic [7:0]       reqCount,
  output logic             reqReady,
  output logic             rspValid,
  output logic [7:0]       rspData,
  input  logic             dpFlag,
  input  logic             romEnable,
  input  logic             pcLoad,
  input  logic [15:0]      pcLoadVal,
  input  logic             spLoad,
  input  logic [7:0]       spLoadVal,
  output logic [15:0]      pc,
  output logic [7:0]       sp,
  output logic             ioRdEn,
  output logic             ioWrEn,
  output logic [3:0]       ioAddr,
  output logic [7:0]       ioWData,
  input  logic [7:0]       ioRdData,
  output logic             tick,
  output logic [CNT_W-1:0] cycleCount
);
  sbuOp_t            opIn;
  sbuStrobe_t        strb;
  logic [RAM_AW-1:0] ramAddr;
  logic [7:0]        ramRData;

  assign opIn    = sbuOp_t'(reqOp);
  assign tick    = strb.tick;
  assign ioWData = reqWData;

  sbu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opIn),
    .reqCount(reqCount), .reqReady(reqReady), .rspValid(rspValid), .strb(strb)
  );

  sbu_dpath #(.RAM_AW(RAM_AW), .CNT_W(CNT_W), .RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqOp(opIn), .reqAddr(reqAddr),
    .dpFlag(dpFlag), .romEnable(romEnable), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal),
    .spLoad(spLoad), .spLoadVal(spLoadVal), .ramRData(ramRData), .ioRdData(ioRdData),
    .ramAddr(ramAddr), .rspData(rspData), .pc(pc), .sp(sp), .ioRdEn(ioRdEn),
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .cycleCount(cycleCount)
  );

  sbu_ram #(.AW(RAM_AW)) ram_i (
    .clk(clk), .we(strb.ramWe), .addr(ramAddr), .wdata(reqWData), .rdata(ramRData)
  );
endmodule

// File: tb/sound_bus_unit_tb.sv
module sound_bus_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] C_IDLE = 3'd0, C_READ = 3'd1, C_WRITE = 3'd2, C_DPRD = 3'd3,
                         C_DPWR = 3'd4, C_PUSH = 3'd5, C_POP = 3'd6, C_FETCH = 3'd7;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, dpFlag = 0, romEnable = 0, pcLoad = 0, spLoad = 0;
  logic [2:0] reqOp = '0;
  logic [15:0] reqAddr = '0, pcLoadVal = '0;
  logic [7:0] reqWData = '0, reqCount = '0, spLoadVal = '0;
  logic reqReady, rspValid, ioRdEn, ioWrEn, tick;
  logic [7:0] rspData, sp, ioWData, ioRdData;
  logic [15:0] pc, cycleCount;
  logic [3:0] ioAddr;

  assign ioRdData = {4'h9, ioAddr};
  always #(CLK_PERIOD/2) clk = ~clk;

  sound_bus_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWData(reqWData), .reqCount(reqCount), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .dpFlag(dpFlag), .romEnable(romEnable), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .spLoad(spLoad), .spLoadVal(spLoadVal), .pc(pc), .sp(sp),
    .ioRdEn(ioRdEn), .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWData(ioWData),
    .ioRdData(ioRdData), .tick(tick), .cycleCount(cycleCount)
  );

  int errors = 0, checks = 0, expTicks = 0, tickSeen = 0;
  logic [7:0] mem [DEPTH];
  logic seenIoRd, seenIoWr;
  logic [3:0] seenIoAddr;
  logic [7:0] seenIoData;

  always @(posedge clk) if (rstN && tick) tickSeen <= tickSeen + 1;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] romModel(input logic [5:0] i);
    return {i, 2'b01} ^ 8'hC3;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (a[15:4] == 12'h00F) return {4'h9, a[3:0]};
    if (romEnable && a >= 16'hFFC0) return romModel(a[5:0]);
    return mem[a[AW-1:0]];
  endfunction

  task automatic doWrite(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = a; reqWData = d;
    #1;
    seenIoWr = ioWrEn; seenIoAddr = ioAddr; seenIoData = ioWData;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    expTicks++;
  endtask

  task automatic doRead(input string tag, input logic [2:0] op, input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = a;
    #1;
    seenIoRd = ioRdEn; seenIoAddr = ioAddr;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    check({tag, " latency"}, rspValid && !reqReady, {rspValid, reqReady}, 2'b10);
    d = rspData;
    expTicks++;
  endtask

  task automatic readExpect(input string tag, input logic [2:0] op, input logic [15:0] a, input logic [7:0] e);
    logic [7:0] d;
    doRead(tag, op, a, d);
    check(tag, d == e, d, e);
  endtask

  task automatic doIdle(input logic [7:0] n);
    int cyc, want;
    want = (n == 0) ? 1 : n;
    @(negedge clk);
    reqValid = 1; reqOp = C_IDLE; reqCount = n;
    @(posedge clk);
    @(negedge clk);
    reqValid = 0;
    cyc = 1;
    while (!reqReady) begin @(negedge clk); cyc++; end
    expTicks += want;
    check("R10 idle length", cyc == want, cyc, want);
    check("R10 tick count", tickSeen == expTicks, tickSeen, expTicks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", reqReady == 1, reqReady, 1);
    check("R1 rspValid/tick", !rspValid && !tick, {rspValid, tick}, 0);
    check("R1 sp", sp == 8'hFF, sp, 8'hFF);
    check("R1 pc", pc == 16'hFFC0, pc, 16'hFFC0);
    check("R1 cycleCount", cycleCount == 0, cycleCount, 0);

    // R6: fill RAM through aliased high addresses
    for (int a = 0; a < DEPTH; a++) begin
      logic [9:0] ia;
      ia = 10'(a);
      d = 8'(a * 7 + 3);
      doWrite(C_WRITE, {ia[5:0], ia}, d);
      mem[a] = d;
    end
    // R2 R3 R6: read back at base addresses
    for (int a = 0; a < DEPTH; a++) readExpect("R6 ram read", C_READ, 16'(a), expRead(16'(a)));

    // R4 I/O writes also land in RAM; R3 I/O read strobe
    for (int i = 0; i < 16; i++) begin
      d = 8'(8'h40 + i);
      doWrite(C_WRITE, 16'h00F0 | 16'(i), d);
      mem[16'h00F0 + i] = d;
      check("R4 ioWrEn", seenIoWr && seenIoAddr == 4'(i) && seenIoData == d,
            {seenIoWr, seenIoAddr, seenIoData}, {1'b1, 4'(i), d});
      readExpect("R4 ram behind io", C_READ, 16'h04F0 | 16'(i), d);
      readExpect("R3 io read", C_READ, 16'h00F0 | 16'(i), {4'h9, 4'(i)});
      check("R3 ioRdEn", seenIoRd && seenIoAddr == 4'(i), {seenIoRd, seenIoAddr}, {1'b1, 4'(i)});
    end

    // R5 ROM overlay
    romEnable = 1;
    for (int i = 0; i < 64; i++) readExpect("R5 rom on", C_READ, 16'hFFC0 + 16'(i), romModel(6'(i)));
    doWrite(C_WRITE, 16'hFFC5, 8'hE7);
    mem[10'h3C5] = 8'hE7;
    readExpect("R5 rom hides write", C_READ, 16'hFFC5, romModel(6'd5));
    romEnable = 0;
    for (int i = 0; i < 64; i++) readExpect("R5 rom off", C_READ, 16'hFFC0 + 16'(i), mem[10'h3C0 + i]);

    // R7 direct page
    for (int f = 0; f < 2; f++) begin
      dpFlag = f[0];
      for (int o = 0; o < 256; o++)
        readExpect("R7 dp read", C_DPRD, {8'hAB, 8'(o)}, expRead({7'b0, f[0], 8'(o)}));
      for (int o = 0; o < 8; o++) begin
        d = 8'(8'h90 + o + f * 16);
        doWrite(C_DPWR, {8'h5C, 8'(o * 17)}, d);
        mem[{1'b0, f[0], 8'(o * 17)}] = d;
        readExpect("R7 dp write", C_READ, {7'b0, f[0], 8'(o * 17)}, d);
      end
    end

    // R8 stack with wrap
    @(negedge clk) begin spLoad = 1; spLoadVal = 8'h02; end
    @(negedge clk) spLoad = 0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] s;
      s = 8'(2 - k);
      doWrite(C_PUSH, 16'h0000, 8'(8'h11 * (k + 1)));
      mem[{2'b01, s}] = 8'(8'h11 * (k + 1));
      check("R8 push sp", sp == 8'(s - 1), sp, 8'(s - 1));
      readExpect("R8 push target", C_READ, {8'h01, s}, 8'(8'h11 * (k + 1)));
    end
    for (int k = 3; k >= 0; k--) begin
      readExpect("R8 pop data", C_POP, 16'h0000, 8'(8'h11 * (k + 1)));
      check("R8 pop sp", sp == 8'(2 - k), sp, 8'(2 - k));
    end

    // R9 fetch
    @(negedge clk) begin pcLoad = 1; pcLoadVal = 16'h0300; end
    @(negedge clk) pcLoad = 0;
    for (int k = 0; k < 5; k++) begin
      readExpect("R9 fetch data", C_FETCH, 16'h0000, mem[16'h0300 + k]);
      check("R9 pc inc", pc == 16'h0301 + 16'(k), pc, 16'h0301 + 16'(k));
    end
    doWrite(C_WRITE, 16'h0123, 8'h3A);
    mem[16'h0123] = 8'h3A;
    readExpect("R9 other op", C_READ, 16'h0123, 8'h3A);
    check("R9 pc unchanged", pc == 16'h0305, pc, 16'h0305);
    romEnable = 1;
    @(negedge clk) begin pcLoad = 1; pcLoadVal = 16'hFFFF; end
    @(negedge clk) pcLoad = 0;
    readExpect("R9 fetch rom", C_FETCH, 16'h0000, romModel(6'h3F));
    check("R9 pc wrap", pc == 16'h0000, pc, 0);
    romEnable = 0;

    // R10 idle stretches and tick count
    check("R10 ticks so far", tickSeen == expTicks, tickSeen, expTicks);
    doIdle(8'd0);
    doIdle(8'd1);
    doIdle(8'd2);
    doIdle(8'd5);
    doIdle(8'd17);
    @(negedge clk);
    check("R10 cycleCount", cycleCount == 16'(expTicks), cycleCount, expTicks);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule